// File: doc/BRIEF.md
# Microcode Dispatch Address Generator

This block turns a data word into a jump target for a microsequencer. A bit field is cut out of a 32-bit source word by rotating the word right and masking it to a chosen width. The field is ORed into a base address to form an index into a dispatch table. The table holds one target micro-address per entry, together with three control flags: `ctl_n`, `ctl_p` and `ctl_r`. A sequencer uses these flags to decide whether to flush the next instruction, push a return address, or return. This block only delivers the flags; it does not act on them.

Two modifiers change how the index is formed. A halfword mode, driven by a location-counter bit, alters the top bit of the rotate count. Two status bits from a page map can also be folded into the lowest index bit: one of them is picked by a selector and ORed in, so it never replaces that bit. The table is a synchronous memory with a separate write port. A lookup presented in one cycle shows its index, target and flags in the next cycle.

Top module: `disp_addr_gen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_valid` is 0 and `disp_idx` is 0.
- R2: The field is the source word rotated right by the effective position, so field bit k equals `src_word[(pos+k) mod 32]`. The rotate wraps from bit 31 back to bit 0.
- R3: For `fld_len` values from 1 to 7, only the low `fld_len` bits of the rotated word form the field; all higher field bits are 0.
- R4: When `fld_len` is 0, no source bit reaches the index. With `map_en` low, `disp_idx` then equals `base_addr`.
- R5: `disp_idx` is `base_addr` bitwise-ORed with the zero-extended 7-bit field. It is not a sum, so every bit set in `base_addr` stays set.
- R6: When `half_mode` is 1, the effective rotate position has bit 4 equal to NOT(`rot_pos[4]` XOR `lc_half`) and bits 3:0 equal to `rot_pos[3:0]`. When `half_mode` is 0, the position is `rot_pos` unchanged.
- R7: When `map_en` is 1, index bit 0 is ORed with `map_st_lo` if `map_sel` is 0, or with `map_st_hi` if `map_sel` is 1. A 1 already present in bit 0 stays 1.
- R8: When `map_en` is 0, `map_sel`, `map_st_lo` and `map_st_hi` have no effect on `disp_idx`.
- R9: `rd_valid` is 1 in exactly the cycle after a cycle with `lookup` high. In that cycle `disp_idx` holds the index of that lookup, and `target`, `ctl_n`, `ctl_p` and `ctl_r` hold the entry stored at that index.
- R10: A write with `wr_en` high stores `{wr_n, wr_p, wr_r, wr_target}` at `wr_addr` at the clock edge. Any lookup in a later cycle returns the new entry.
- R11: When a write and a lookup hit the same index in the same cycle, the lookup returns the entry as it was before the write. The new entry is returned from the next lookup onward.
- R12: In a cycle without `lookup`, `disp_idx`, `target` and the three flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_word | input | 32 | Word the field is extracted from |
| rot_pos | input | 5 | Right-rotate position |
| fld_len | input | 3 | Field width, 0 to 7 |
| base_addr | input | 11 | Base table index |
| half_mode | input | 1 | Halfword mode, alters rotate bit 4 |
| lc_half | input | 1 | Location-counter bit used in halfword mode |
| map_en | input | 1 | Fold a page-map status bit into index bit 0 |
| map_sel | input | 1 | 0 picks `map_st_lo`, 1 picks `map_st_hi` |
| map_st_lo | input | 1 | Page-map status bit (map output bit 18) |
| map_st_hi | input | 1 | Page-map status bit (map output bit 19) |
| lookup | input | 1 | Start a table lookup this cycle |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 11 | Table write index |
| wr_target | input | 14 | Target address to store |
| wr_n | input | 1 | N flag to store |
| wr_p | input | 1 | P flag to store |
| wr_r | input | 1 | R flag to store |
| rd_valid | output | 1 | Lookup result valid |
| disp_idx | output | 11 | Index that was looked up |
| target | output | 14 | Target micro-address read from the table |
| ctl_n | output | 1 | N flag read from the table |
| ctl_p | output | 1 | P flag read from the table |
| ctl_r | output | 1 | R flag read from the table |

## Verification
A table write and a lookup can land in the same cycle. The bench provokes this by driving a write to exactly the index that a lookup computes in the same cycle, with `src_word`, `base_addr` and the map bits chosen so that the computed index is that write index. The result is judged correct when that lookup returns the entry as it was before the write, and a second lookup of the same index returns the new entry. The bench also interleaves random writes with random lookups in separate cycles, so the bench's own model of the table is checked against the design throughout the run.

// File: rtl/dispgen_pkg.sv
package dispgen_pkg;

  // Which page-map status bit feeds index bit 0
  typedef enum logic {
    MAP_PICK_LO = 1'b0,
    MAP_PICK_HI = 1'b1
  } map_pick_e;

  // Top rotate-count bit in halfword mode
  function automatic logic half_top_bit(input logic pos_top, input logic lc_bit);
    return ~(pos_top ^ lc_bit);
  endfunction

endpackage

// File: rtl/dg_field_extract.sv
module dg_field_extract #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 5,
  parameter int LEN_W  = 3,
  parameter int FLD_W  = 7
) (
  input  logic [DATA_W-1:0] src,
  input  logic [POS_W-1:0]  pos,
  input  logic [LEN_W-1:0]  len,
  input  logic              half,
  input  logic              lc_bit,
  output logic [FLD_W-1:0]  fld
);
  import dispgen_pkg::*;

  logic [POS_W-1:0]    eff_pos;
  logic [2*DATA_W-1:0] doubled;
  logic [DATA_W-1:0]   rotated;
  logic [FLD_W-1:0]    mask;

  always_comb begin
    eff_pos = pos;
    if (half) eff_pos[POS_W-1] = half_top_bit(pos[POS_W-1], lc_bit);
  end

  assign doubled = {src, src} >> eff_pos;
  assign rotated = doubled[DATA_W-1:0];

  for (genvar i = 0; i < FLD_W; i++) begin : g_mask
    assign mask[i] = (int'(len) > i);
  end

  assign fld = rotated[FLD_W-1:0] & mask;
endmodule

// File: rtl/dg_index_form.sv
module dg_index_form #(
  parameter int IDX_W = 11,
  parameter int FLD_W = 7
) (
  input  logic [IDX_W-1:0] base,
  input  logic [FLD_W-1:0] fld,
  input  logic             map_en,
  input  logic             map_sel,
  input  logic             st_lo,
  input  logic             st_hi,
  output logic [IDX_W-1:0] idx
);
  import dispgen_pkg::*;

  localparam int PAD_W = IDX_W - FLD_W;

  map_pick_e pick;
  logic      st_bit;

  assign pick   = map_pick_e'(map_sel);
  assign st_bit = (pick == MAP_PICK_HI) ? st_hi : st_lo;

  always_comb begin
    idx    = base | {{PAD_W{1'b0}}, fld};
    idx[0] = idx[0] | (map_en & st_bit);
  end
endmodule

// File: rtl/dg_table.sv
module dg_table #(
  parameter int IDX_W  = 11,
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen #(
  parameter int DATA_W = 32,
  parameter int POS_W  = 5,
  parameter int LEN_W  = 3,
  parameter int IDX_W  = 11,
  parameter int TGT_W  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] src_word,
  input  logic [POS_W-1:0]  rot_pos,
  input  logic [LEN_W-1:0]  fld_len,
  input  logic [IDX_W-1:0]  base_addr,
  input  logic              half_mode,
  input  logic              lc_half,
  input  logic              map_en,
  input  logic              map_sel,
  input  logic              map_st_lo,
  input  logic              map_st_hi,
  input  logic              lookup,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [TGT_W-1:0]  wr_target,
  input  logic              wr_n,
  input  logic              wr_p,
  input  logic              wr_r,
  output logic              rd_valid,
  output logic [IDX_W-1:0]  disp_idx,
  output logic [TGT_W-1:0]  target,
  output logic              ctl_n,
  output logic              ctl_p,
  output logic              ctl_r
);
  localparam int FLD_W  = (1 << LEN_W) - 1;
  localparam int WORD_W = TGT_W + 3;

  logic [FLD_W-1:0]  fld;
  logic [IDX_W-1:0]  idx_next;
  logic [WORD_W-1:0] rd_word;

  dg_field_extract #(
    .DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W), .FLD_W(FLD_W)
  ) i_extract (
    .src(src_word), .pos(rot_pos), .len(fld_len),
    .half(half_mode), .lc_bit(lc_half), .fld(fld)
  );

  dg_index_form #(.IDX_W(IDX_W), .FLD_W(FLD_W)) i_index (
    .base(base_addr), .fld(fld), .map_en(map_en), .map_sel(map_sel),
    .st_lo(map_st_lo), .st_hi(map_st_hi), .idx(idx_next)
  );

  dg_table #(.IDX_W(IDX_W), .WORD_W(WORD_W)) i_table (
    .clk(clk), .rd_en(lookup), .rd_addr(idx_next),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data({wr_n, wr_p, wr_r, wr_target}),
    .rd_data(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      disp_idx <= '0;
    end else begin
      rd_valid <= lookup;
      if (lookup) disp_idx <= idx_next;
    end
  end

  assign {ctl_n, ctl_p, ctl_r, target} = rd_word;
endmodule

// File: rtl/dg_checker.sv
module dg_checker #(
  parameter int IDX_W = 11,
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             lookup,
  input logic [LEN_W-1:0] fld_len,
  input logic [IDX_W-1:0] base_addr,
  input logic             map_en,
  input logic             map_sel,
  input logic             map_st_lo,
  input logic             map_st_hi,
  input logic             rd_valid,
  input logic [IDX_W-1:0] disp_idx
);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    lookup |=> rd_valid);

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (rst)
    !lookup |=> !rd_valid);

  assert_idx_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !lookup |=> $stable(disp_idx));

  assert_empty_mask_R4: assert property (@(posedge clk) disable iff (rst)
    (lookup && fld_len == '0 && !map_en) |=> disp_idx == $past(base_addr));

  assert_base_kept_R5: assert property (@(posedge clk) disable iff (rst)
    lookup |=> (disp_idx & $past(base_addr)) == $past(base_addr));

  assert_map_or_R7: assert property (@(posedge clk) disable iff (rst)
    (lookup && map_en && (map_sel ? map_st_hi : map_st_lo)) |=> disp_idx[0]);
endmodule

bind disp_addr_gen dg_checker #(.IDX_W(IDX_W), .LEN_W(LEN_W)) i_dg_checker (
  .clk(clk), .rst(rst), .lookup(lookup), .fld_len(fld_len),
  .base_addr(base_addr), .map_en(map_en), .map_sel(map_sel),
  .map_st_lo(map_st_lo), .map_st_hi(map_st_hi),
  .rd_valid(rd_valid), .disp_idx(disp_idx)
);

// File: tb/test_disp_addr_gen.sv
module test_disp_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_word = '0;
  logic [4:0]  rot_pos = '0;
  logic [2:0]  fld_len = '0;
  logic [10:0] base_addr = '0;
  logic        half_mode = 0, lc_half = 0, map_en = 0, map_sel = 0;
  logic        map_st_lo = 0, map_st_hi = 0, lookup = 0, wr_en = 0;
  logic [10:0] wr_addr = '0;
  logic [13:0] wr_target = '0;
  logic        wr_n = 0, wr_p = 0, wr_r = 0;
  logic        rd_valid;
  logic [10:0] disp_idx;
  logic [13:0] target;
  logic        ctl_n, ctl_p, ctl_r;

  int errors = 0;
  int checks = 0;
  logic [16:0] mdl [2048];

  always #4 clk = ~clk;

  disp_addr_gen i_disp_addr_gen (
    .clk(clk), .rst(rst), .src_word(src_word), .rot_pos(rot_pos),
    .fld_len(fld_len), .base_addr(base_addr), .half_mode(half_mode),
    .lc_half(lc_half), .map_en(map_en), .map_sel(map_sel),
    .map_st_lo(map_st_lo), .map_st_hi(map_st_hi), .lookup(lookup),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_target(wr_target),
    .wr_n(wr_n), .wr_p(wr_p), .wr_r(wr_r), .rd_valid(rd_valid),
    .disp_idx(disp_idx), .target(target), .ctl_n(ctl_n),
    .ctl_p(ctl_p), .ctl_r(ctl_r)
  );

  function automatic logic [10:0] exp_idx(
      input logic [31:0] s, input logic [4:0] p, input logic [2:0] l,
      input logic [10:0] b, input logic h, input logic lc,
      input logic me, input logic ms, input logic s0, input logic s1);
    logic [4:0]  ep;
    logic [6:0]  f;
    logic [10:0] r;
    ep = p;
    if (h) ep[4] = !(p[4] != lc);
    f = '0;
    for (int k = 0; k < 7; k++)
      if (k < int'(l)) f[k] = s[(int'(ep) + k) % 32];
    r = b | {4'b0, f};
    if (me && (ms ? s1 : s0)) r[0] = 1'b1;
    return r;
  endfunction

  function automatic logic [16:0] pat(input int i);
    pat = {i[0], i[1] ^ i[3], i[2], 14'((i * 37 + 5) & 16'h3fff)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [31:0] s, input logic [4:0] p,
      input logic [2:0] l, input logic [10:0] b, input logic h,
      input logic lc, input logic me, input logic ms, input logic s0,
      input logic s1);
    src_word = s; rot_pos = p; fld_len = l; base_addr = b;
    half_mode = h; lc_half = lc; map_en = me; map_sel = ms;
    map_st_lo = s0; map_st_hi = s1;
  endtask

  // Lookup at a falling edge; results checked one falling edge later
  task automatic look(input string req, input logic [31:0] s,
      input logic [4:0] p, input logic [2:0] l, input logic [10:0] b,
      input logic h, input logic lc, input logic me, input logic ms,
      input logic s0, input logic s1);
    logic [10:0] e;
    set_in(s, p, l, b, h, lc, me, ms, s0, s1);
    e = exp_idx(s, p, l, b, h, lc, me, ms, s0, s1);
    lookup = 1'b1;
    @(negedge clk);
    lookup = 1'b0;
    check({req, " idx"}, int'(disp_idx), int'(e));
    check({req, " entry R9"}, int'({ctl_n, ctl_p, ctl_r, target}), int'(mdl[e]));
    check({req, " valid R9"}, int'(rd_valid), 1);
  endtask

  task automatic write(input logic [10:0] a, input logic [16:0] d);
    wr_en = 1'b1; wr_addr = a;
    {wr_n, wr_p, wr_r, wr_target} = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl[a] = d;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [16:0] old_w, new_w;
    logic [10:0] e;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(rd_valid), 0);
    check("R1 idx in reset", int'(disp_idx), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", int'(rd_valid), 0);
    check("R1 idx after reset", int'(disp_idx), 0);

    // R10: load every entry, then read back through lookups
    for (int i = 0; i < 2048; i++) begin
      wr_en = 1'b1; wr_addr = 11'(i);
      {wr_n, wr_p, wr_r, wr_target} = pat(i);
      mdl[i] = pat(i);
      @(negedge clk);
    end
    wr_en = 1'b0;

    // R3 widths
    look("R3 len7", 32'hffffffff, 5'd0, 3'd7, 11'h000, 0, 0, 0, 0, 0, 0);
    look("R3 len1", 32'hffffffff, 5'd0, 3'd1, 11'h000, 0, 0, 0, 0, 0, 0);
    look("R3 len3", 32'h000000f0, 5'd3, 3'd3, 11'h400, 0, 0, 0, 0, 0, 0);
    // R2 rotate and wrap
    look("R2 pos9", 32'h00000200, 5'd9, 3'd1, 11'h000, 0, 0, 0, 0, 0, 0);
    look("R2 wrap", 32'h00000001, 5'd31, 3'd2, 11'h000, 0, 0, 0, 0, 0, 0);
    check("R2 wrap value", int'(disp_idx), 2);
    // R4 empty mask
    look("R4 len0", 32'hffffffff, 5'd5, 3'd0, 11'h155, 0, 0, 0, 0, 0, 0);
    check("R4 base only", int'(disp_idx), 11'h155);
    // R5 OR not add
    look("R5 or", 32'h0000007f, 5'd0, 3'd7, 11'h07f, 0, 0, 0, 0, 0, 0);
    check("R5 no carry", int'(disp_idx), 11'h07f);
    // R6 halfword rotate
    look("R6 lc1", 32'h00080000, 5'd19, 3'd1, 11'h000, 1, 1, 0, 0, 0, 0);
    check("R6 pos19 kept", int'(disp_idx), 1);
    look("R6 lc0", 32'h00080000, 5'd19, 3'd1, 11'h000, 1, 0, 0, 0, 0, 0);
    check("R6 pos3 used", int'(disp_idx), 0);
    look("R6 flip up", 32'h00080000, 5'd3, 3'd1, 11'h000, 1, 0, 0, 0, 0, 0);
    check("R6 bit4 set", int'(disp_idx), 1);
    // R7 map OR
    look("R7 lo", 32'h0, 5'd0, 3'd0, 11'h100, 0, 0, 1, 0, 1, 0);
    check("R7 lo set", int'(disp_idx), 11'h101);
    look("R7 hi", 32'h0, 5'd0, 3'd0, 11'h100, 0, 0, 1, 1, 1, 0);
    check("R7 hi clear", int'(disp_idx), 11'h100);
    look("R7 keep", 32'h0, 5'd0, 3'd0, 11'h101, 0, 0, 1, 1, 0, 0);
    check("R7 not replaced", int'(disp_idx), 11'h101);
    // R8 map off
    look("R8 off", 32'h0, 5'd0, 3'd0, 11'h100, 0, 0, 0, 1, 1, 1);
    check("R8 ignored", int'(disp_idx), 11'h100);

    // R12 hold without lookup, R9 valid drop
    e = disp_idx;
    old_w = {ctl_n, ctl_p, ctl_r, target};
    set_in(32'hffffffff, 5'd0, 3'd7, 11'h7ff, 0, 0, 1, 0, 1, 1);
    @(negedge clk);
    check("R9 valid low", int'(rd_valid), 0);
    check("R12 idx hold", int'(disp_idx), int'(e));
    check("R12 entry hold", int'({ctl_n, ctl_p, ctl_r, target}), int'(old_w));

    // R11 same-cycle write and lookup
    e = exp_idx(32'h5, 5'd0, 3'd3, 11'h230, 0, 0, 0, 0, 0, 0);
    old_w = mdl[e];
    new_w = ~old_w;
    set_in(32'h5, 5'd0, 3'd3, 11'h230, 0, 0, 0, 0, 0, 0);
    lookup = 1'b1; wr_en = 1'b1; wr_addr = e;
    {wr_n, wr_p, wr_r, wr_target} = new_w;
    @(negedge clk);
    lookup = 1'b0; wr_en = 1'b0;
    check("R11 old entry", int'({ctl_n, ctl_p, ctl_r, target}), int'(old_w));
    mdl[e] = new_w;
    look("R11 new entry", 32'h5, 5'd0, 3'd3, 11'h230, 0, 0, 0, 0, 0, 0);

    // Random mix, with writes in separate cycles (R2 R3 R5 R10)
    for (int n = 0; n < 400; n++) begin
      if ($urandom % 4 == 0)
        write(11'($urandom), 17'($urandom));
      look("R5 random", $urandom, 5'($urandom), 3'($urandom), 11'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule